// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block is a down-counting interrupt timer for one processor core. Software programs an initial count, a clock divide setting and a vector entry. The vector entry holds the vector, a mask, a one-shot/periodic select and a read-only delivery-status flag. A write to the initial count loads the running counter and restarts the prescaler. The counter then decrements once per divided tick. When it reaches zero, the block issues a one-cycle request strobe carrying the programmed vector, unless the entry is masked.

In periodic mode the counter reloads from the initial count and the requests repeat. In one-shot mode the counter stays at zero. The delivery-status flag rises with each request and falls when the downstream consumer returns an accept pulse.

Top module: `irq_countdown_timer`

Register select (`reg_addr`): 0 = vector entry, 1 = initial count, 2 = current count (read-only), 3 = divide setting.

## Requirements
- R1: After reset, the vector entry reads 0x0001_0000 (masked, one-shot, vector 0), the initial count, current count and divide setting read 0, `irq_req` is low and the status flag is 0.
- R2: A write to register 1 stores the value, copies it into the current count on the same edge and restarts the prescaler. Writing 0 stops the timer: the count stays 0 and no request follows.
- R3: The divide setting uses bits 3, 1 and 0 of register 3; bit 2 is ignored. With bit 2 cleared, code 0x0 divides by 2, 0x1 by 4, 0x2 by 8, 0x3 by 16, 0x8 by 32, 0x9 by 64, 0xA by 128 and 0xB by 1.
- R4: With initial count N and divisor D, the current count drops by one every D clocks. `irq_req` is first high in the cycle after the N*D-th clock edge that follows the write edge, with `irq_vec` equal to entry bits 7:0.
- R5: In one-shot mode (entry bit 17 = 0), the count stays at 0 after expiry and no further request is issued.
- R6: In periodic mode (entry bit 17 = 1), the count reloads from the initial count on expiry, and requests repeat every N*D clocks.
- R7: When entry bit 16 (mask) is 1, expiry raises no request and does not set the status flag. The count still runs to zero.
- R8: Entry bit 12 (status) reads 1 from the request cycle until an `irq_ack` pulse clears it. If an expiry and an ack fall in the same cycle, the status flag stays 1.
- R9: The vector entry reads back bits 17, 16 and 7:0 as written, with the status flag in bit 12 and all other bits 0. The divide setting reads back its 4 written bits, and the initial count reads back its value.
- R10: Writes to register 2 (current count) are ignored: they change neither the count nor the time of expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_ack | input | 1 | Downstream accept pulse, clears the status flag |
| irq_req | output | 1 | One-cycle interrupt request strobe |
| irq_vec | output | 8 | Vector carried with `irq_req` |

## Verification
The race that matters is an expiry and a downstream accept landing on the same clock edge. The status flag must then end up set, because a fresh request is outstanding. The bench provokes this with a periodic count of 1 at divide-by-1, so that expiry happens on every edge, while it holds `irq_ack` high for several cycles. It then reads bit 12 and expects 1. After it stops the timer, one lone ack must bring the flag to 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;
  localparam int PS_W   = 7;   // prescaler width, max divide 128

  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_INIT  = 2'd1,
    SEL_CUR   = 2'd2,
    SEL_DIV   = 2'd3
  } reg_sel_e;

  localparam int B_PERIODIC = 17;
  localparam int B_MASK     = 16;
  localparam int B_STATUS   = 12;

  // log2 of the divisor: the three meaningful code bits plus one, wrapping
  function automatic logic [2:0] div_shift(input logic [3:0] code);
    return {code[3], code[1], code[0]} + 3'd1;
  endfunction

  // terminal value of the prescaler counter
  function automatic logic [PS_W-1:0] div_limit(input logic [3:0] code);
    logic [PS_W:0] one_hot;
    one_hot = (PS_W+1)'(1) << div_shift(code);
    return PS_W'(one_hot - (PS_W+1)'(1));
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [3:0] div_code,
  output logic       tick
);
  logic [PS_W-1:0] pcnt;
  logic [PS_W-1:0] lim;

  assign lim  = div_limit(div_code);
  assign tick = (pcnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pcnt <= '0;
    else if (tick)         pcnt <= '0;
    else                   pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  input  logic         periodic,
  input  logic         tick,
  output logic [W-1:0] cur,
  output logic         expire
);
  logic at_one;
  assign at_one = (cur == W'(1));
  assign expire = tick && at_one && !load;

  always_ff @(posedge clk) begin
    if (!rst_n)                         cur <= '0;
    else if (load)                      cur <= load_val;
    else if (tick && cur != '0) begin
      if (at_one) cur <= periodic ? reload_val : '0;
      else        cur <= cur - 1'b1;
    end
  end
endmodule

// File: rtl/tmr_notify.sv
module tmr_notify (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic       masked,
  input  logic [7:0] vec_in,
  input  logic       ack,
  output logic       fire,
  output logic       irq_req,
  output logic [7:0] irq_vec,
  output logic       pending
);
  assign fire = expire && !masked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      pending <= 1'b0;
    end else begin
      irq_req <= fire;
      if (fire) irq_vec <= vec_in;
      if (fire)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [7:0]        irq_vec
);
  logic [7:0]       vec_q;
  logic             mask_q;
  logic             periodic_q;
  logic [CNT_W-1:0] init_q;
  logic [3:0]       div_q;

  // named internal events
  logic             load_w;
  logic             div_wr_w;
  logic             tick_w;
  logic             expire_w;
  logic             fire_w;
  logic             pending_w;
  logic [CNT_W-1:0] cur_count;
  logic             unused_wdata;

  assign load_w   = reg_wr && (reg_addr == SEL_INIT);
  assign div_wr_w = reg_wr && (reg_addr == SEL_DIV);
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q      <= '0;
      mask_q     <= 1'b1;
      periodic_q <= 1'b0;
      init_q     <= '0;
      div_q      <= '0;
    end else if (reg_wr) begin
      unique case (reg_sel_e'(reg_addr))
        SEL_ENTRY: begin
          vec_q      <= reg_wdata[7:0];
          mask_q     <= reg_wdata[B_MASK];
          periodic_q <= reg_wdata[B_PERIODIC];
        end
        SEL_INIT: init_q <= reg_wdata[CNT_W-1:0];
        SEL_DIV:  div_q  <= reg_wdata[3:0];
        default: ;
      endcase
    end
  end

  tmr_prescaler u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (load_w || div_wr_w),
    .div_code (div_q),
    .tick     (tick_w)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_w),
    .load_val   (reg_wdata[CNT_W-1:0]),
    .reload_val (init_q),
    .periodic   (periodic_q),
    .tick       (tick_w),
    .cur        (cur_count),
    .expire     (expire_w)
  );

  tmr_notify u_ntf (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire_w),
    .masked  (mask_q),
    .vec_in  (vec_q),
    .ack     (irq_ack),
    .fire    (fire_w),
    .irq_req (irq_req),
    .irq_vec (irq_vec),
    .pending (pending_w)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel_e'(reg_addr))
      SEL_ENTRY: begin
        reg_rdata[7:0]        = vec_q;
        reg_rdata[B_STATUS]   = pending_w;
        reg_rdata[B_MASK]     = mask_q;
        reg_rdata[B_PERIODIC] = periodic_q;
      end
      SEL_INIT: reg_rdata[CNT_W-1:0] = init_q;
      SEL_CUR:  reg_rdata[CNT_W-1:0] = cur_count;
      SEL_DIV:  reg_rdata[3:0]       = div_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_w,
  input logic         tick_w,
  input logic         expire_w,
  input logic         fire_w,
  input logic         pending_w,
  input logic         mask_q,
  input logic         periodic_q,
  input logic         irq_req,
  input logic         irq_ack,
  input logic [W-1:0] init_q,
  input logic [W-1:0] cur_count
);
  // R2
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> (cur_count == init_q));

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_w && !load_w && cur_count > W'(1)) |=> (cur_count == $past(cur_count) - W'(1)));

  // R5
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_count == '0 && !load_w) |=> (cur_count == '0));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && periodic_q) |=> (cur_count == $past(init_q)));

  // R7
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !$past(mask_q));

  // R8
  req_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> pending_w);

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !fire_w) |=> !pending_w);
endmodule

bind irq_countdown_timer tmr_chk #(.W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_w     (load_w),
  .tick_w     (tick_w),
  .expire_w   (expire_w),
  .fire_w     (fire_w),
  .pending_w  (pending_w),
  .mask_q     (mask_q),
  .periodic_q (periodic_q),
  .irq_req    (irq_req),
  .irq_ack    (irq_ack),
  .init_q     (init_q),
  .cur_count  (cur_count)
);

// File: tb/irq_countdown_timer_tb_top.sv
`timescale 1ns/100ps
module irq_countdown_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_ack = 1'b0;
  logic        irq_req;
  logic [7:0]  irq_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_countdown_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  function automatic int divisor(input logic [3:0] code);
    case (code & 4'hB)
      4'h0: return 2;    4'h1: return 4;
      4'h2: return 8;    4'h3: return 16;
      4'h8: return 32;   4'h9: return 64;
      4'hA: return 128;  default: return 1;
    endcase
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  // edges until irq_req is seen, 0 if none within lim
  task automatic wait_irq(input int lim, output int k);
    k = 0;
    for (int i = 1; i <= lim; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq_req) begin k = i; break; end
    end
  endtask

  task automatic count_irqs(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq_req) c++;
    end
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1; @(posedge clk); @(negedge clk); irq_ack = 1'b0;
  endtask

  initial begin
    #900000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int k, c;
    step(3);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(0, d); check("R1 entry", d, 32'h0001_0000);
    rd(1, d); check("R1 init", d, 0);
    rd(2, d); check("R1 cur", d, 0);
    rd(3, d); check("R1 div", d, 0);
    check("R1 irq_req", irq_req, 0);

    // R3 R4 R5: sweep all 16 divide codes, one-shot, N=3
    for (int code = 0; code < 16; code++) begin
      int dv;
      dv = divisor(4'(code));
      wr(3, 32'(code));
      rd(3, d); check("R9 div readback", d, code);
      wr(0, 32'h30 + 32'(code));
      wr(1, 3);
      wait_irq(3 * dv + 10, k);
      check("R3 expiry cycle", k, 3 * dv);
      check("R4 vector", irq_vec, 32'h30 + 32'(code));
      count_irqs(2 * dv + 4, c);
      check("R5 no repeat", c, 0);
      rd(2, d); check("R5 count held at zero", d, 0);
      ack_pulse();
    end

    // R4 count sweep at divide-by-1
    wr(3, 32'hB);
    for (int n = 1; n <= 6; n++) begin
      wr(1, 32'(n));
      wait_irq(20, k);
      check("R4 expiry N*1", k, n);
    end
    wr(3, 32'h0);
    for (int n = 1; n <= 4; n++) begin
      wr(1, 32'(n));
      wait_irq(40, k);
      check("R4 expiry N*2", k, 2 * n);
    end
    ack_pulse();

    // R2 load and mid-count read
    wr(3, 32'hB);
    wr(1, 10);
    rd(2, d); check("R2 loaded", d, 10);
    step(3);
    rd(2, d); check("R4 mid count", d, 7);
    // R2 restart while counting
    wr(1, 5);
    wait_irq(20, k); check("R2 restart expiry", k, 5);
    // R2 write zero stops
    wr(1, 8); step(2);
    wr(1, 0);
    count_irqs(20, c); check("R2 zero stops", c, 0);
    rd(2, d); check("R2 count zero", d, 0);
    ack_pulse();

    // R6 periodic N=4 /2
    wr(3, 32'h0);
    wr(0, (32'h1 << 17) | 32'h5A);
    wr(1, 4);
    for (int p = 0; p < 3; p++) begin
      wait_irq(40, k); check("R6 period", k, 8);
      check("R6 vector", irq_vec, 32'h5A);
    end
    wr(1, 0);
    count_irqs(20, c); check("R6 stopped", c, 0);
    // R8 status then ack
    rd(0, d); check("R8 status set", d[12], 1);
    ack_pulse();
    rd(0, d); check("R8 status cleared", d[12], 0);

    // R8 collision: expiry every edge while ack held
    wr(3, 32'hB);
    wr(1, 1);
    irq_ack = 1'b1;
    step(5);
    rd(0, d); check("R8 fire wins over ack", d[12], 1);
    irq_ack = 1'b0;
    wr(1, 0);
    step(2);
    ack_pulse();
    rd(0, d); check("R8 lone ack clears", d[12], 0);

    // R7 mask
    wr(0, (32'h1 << 16) | 32'h77);
    wr(1, 3);
    count_irqs(10, c); check("R7 masked no irq", c, 0);
    rd(2, d); check("R7 count ran out", d, 0);
    rd(0, d); check("R7 status stays 0", d[12], 0);

    // R10 write to current count ignored
    wr(0, 32'h21);
    wr(1, 7);
    step(2);
    wr(2, 32'h55);
    wait_irq(20, k); check("R10 expiry unchanged", k + 3, 7);
    wr(2, 32'h55);
    rd(2, d); check("R10 count stays zero", d, 0);
    ack_pulse();

    // R9 readback
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); check("R9 entry readback", d, 32'h0003_00FF);
    wr(1, 32'h12345);
    rd(1, d); check("R9 init readback", d, 32'h12345);
    wr(1, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule